// File: doc/BRIEF.md
# Channel Interrupt Request Latch

This unit sits next to one DMA channel and turns the channel engine's completion and abort events into a maskable, level-type interrupt. Software sees four word registers. The first is a live status view that follows the event inputs directly. The second is a sticky request view that captures every event and is cleared bit by bit with write-one-to-clear. The third is an enable mask. The fourth is a read-only detect view that shows which captured requests are also enabled.

The interrupt output is the OR of the detect bits, taken through a register. When no detect bit is set, the output stays low. This lets several channel units feed one wired-OR or OR-gated interrupt line, and a handler can find the channel that raised it by reading each channel's detect view.

Only two bit positions are implemented: bit 1 for "transfer finished" and bit 13 for "transfer aborted". An aborted transfer may raise both bits. The unit records each of them on its own.

Top module: `irqlatch_top`

## Requirements
- R1: After reset, every register reads zero and `irqOut` is low.
- R2: Offset 0x10 reads the live event inputs: bit 1 equals `evtDone` and bit 13 equals `evtAbort`, in the same cycle. Writes to 0x10 change no register.
- R3: A request bit at offset 0x14 becomes set on the clock edge where its event input is high, whatever the enable mask holds. It then stays set until it is cleared.
- R4: A write to 0x14 clears each request bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: If an event and a write-one-to-clear of the same bit fall on the same edge, the bit ends up set.
- R6: Offset 0x18 is the enable mask. It is written with bits 1 and 13 of the write data and reads back those two bits.
- R7: Offset 0x1C always reads the request register ANDed with the enable mask. Writes to 0x1C change nothing.
- R8: `irqOut` is registered. It is high in the cycle after any detect bit is nonzero, and low in the cycle after all detect bits are zero.
- R9: Bits other than 1 and 13 read as zero in every view. Any address other than the four offsets reads zero.
- R10: Done and abort events on the same edge are both captured. Each is then cleared on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte address for reads and writes |
| regWrEn | input | 1 | Write strobe for the register at `regAddr` |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| evtDone | input | 1 | Transfer-finished event from the channel engine |
| evtAbort | input | 1 | Transfer-aborted event from the channel engine |
| irqOut | output | 1 | Channel interrupt request, registered |

## Verification
The bound assertions check on every cycle the properties that hold at all times. They check that each event sets its request bit on the next edge, including when a clear hits the same bit, and that a clear with no event removes the bit. They also check that the request bits hold when nothing acts on them, that the raw and detect reads match the event inputs and the stored state, and that the interrupt follows the detect bits one cycle later. The bench's scenarios are needed for the rest: the reset values, mask writes that keep only two bits, writes to read-only views having no effect, zero reads at unmapped addresses, and a cycle-by-cycle comparison against a behavioural model through runs that mix events, clears and mask changes.

// File: rtl/irqlatch_pkg.sv
package irqlatch_pkg;
  localparam int OFS_RAW = 'h10;
  localparam int OFS_REQ = 'h14;
  localparam int OFS_EN  = 'h18;
  localparam int OFS_DET = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_REQ,
    SEL_EN,
    SEL_DET
  } regSel_e;

  typedef struct packed {
    logic    clrReq;
    logic    wrMask;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqlatch_ctrl.sv
module irqlatch_ctrl
  import irqlatch_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(OFS_REQ);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_DET = ADDR_W'(OFS_DET);

  always_comb begin
    strobe.clrReq = regWrEn && (regAddr == A_REQ);
    strobe.wrMask = regWrEn && (regAddr == A_EN);
    unique case (regAddr)
      A_RAW:   strobe.rdSel = SEL_RAW;
      A_REQ:   strobe.rdSel = SEL_REQ;
      A_EN:    strobe.rdSel = SEL_EN;
      A_DET:   strobe.rdSel = SEL_DET;
      default: strobe.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irqlatch_datapath.sv
module irqlatch_datapath
  import irqlatch_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DONE_BIT  = 1,
  parameter int ABORT_BIT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evtDone,
  input  logic              evtAbort,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [DATA_W-1:0] reqQ,
  output logic [DATA_W-1:0] enQ
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << DONE_BIT) | (DATA_W'(1) << ABORT_BIT);

  logic [DATA_W-1:0] rawVec;
  logic [DATA_W-1:0] detVec;
  logic              irqQ;

  always_comb begin
    rawVec            = '0;
    rawVec[DONE_BIT]  = evtDone;
    rawVec[ABORT_BIT] = evtAbort;
  end

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    if (IMPL_MASK[gi]) begin : g_live
      logic reqBit;
      logic enBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          reqBit <= 1'b0;
          enBit  <= 1'b0;
        end else begin
          // an arriving event outranks a simultaneous clear
          reqBit <= rawVec[gi] | (reqBit & ~(strobe.clrReq & wrData[gi]));
          if (strobe.wrMask) enBit <= wrData[gi];
        end
      end
      assign reqQ[gi] = reqBit;
      assign enQ[gi]  = enBit;
    end else begin : g_tie
      assign reqQ[gi] = 1'b0;
      assign enQ[gi]  = 1'b0;
    end
  end

  assign detVec = reqQ & enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |detVec;
  end

  assign irqOut = irqQ;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_RAW: rdData = rawVec;
      SEL_REQ: rdData = reqQ;
      SEL_EN:  rdData = enQ;
      SEL_DET: rdData = detVec;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqlatch_top.sv
module irqlatch_top
  import irqlatch_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DONE_BIT  = 1,
  parameter int ABORT_BIT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evtDone,
  input  logic              evtAbort,
  output logic              irqOut
);
  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] reqQ;
  logic [DATA_W-1:0] enQ;

  irqlatch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  irqlatch_datapath #(
    .DATA_W    (DATA_W),
    .DONE_BIT  (DONE_BIT),
    .ABORT_BIT (ABORT_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .evtDone  (evtDone),
    .evtAbort (evtAbort),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .reqQ     (reqQ),
    .enQ      (enQ)
  );
endmodule

// File: rtl/irqlatch_checker.sv
module irqlatch_checker
  import irqlatch_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DONE_BIT  = 1,
  parameter int ABORT_BIT = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              evtDone,
  input logic              evtAbort,
  input logic              irqOut,
  input logic [DATA_W-1:0] reqQ,
  input logic [DATA_W-1:0] enQ
);
  localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(OFS_REQ);
  localparam logic [ADDR_W-1:0] A_DET = ADDR_W'(OFS_DET);

  logic clrDone;
  logic touchReq;
  assign clrDone  = regWrEn && (regAddr == A_REQ) && regWrData[DONE_BIT];
  assign touchReq = (regWrEn && (regAddr == A_REQ)) || evtDone || evtAbort;

  a_r3_done_captured: assert property (@(posedge clk) disable iff (!rstN)
    evtDone |=> reqQ[DONE_BIT]);

  a_r10_abort_captured: assert property (@(posedge clk) disable iff (!rstN)
    evtAbort |=> reqQ[ABORT_BIT]);

  a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrDone && evtDone) |=> reqQ[DONE_BIT]);

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (clrDone && !evtDone) |=> !reqQ[DONE_BIT]);

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !touchReq |=> $stable(reqQ));

  a_r2_raw_live: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_RAW) |-> (regRdData[DONE_BIT] == evtDone &&
                            regRdData[ABORT_BIT] == evtAbort &&
                            $countones(regRdData) == 32'(evtDone) + 32'(evtAbort)));

  a_r7_detect_view: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_DET) |-> regRdData == (reqQ & enQ));

  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqQ & enQ)) |=> irqOut);

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(|(reqQ & enQ)) |=> !irqOut);
endmodule

bind irqlatch_top irqlatch_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .DONE_BIT  (DONE_BIT),
  .ABORT_BIT (ABORT_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .evtDone   (evtDone),
  .evtAbort  (evtAbort),
  .irqOut    (irqOut),
  .reqQ      (reqQ),
  .enQ       (enQ)
);

// File: tb/irqlatch_top_tb.sv
module irqlatch_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evtDone = 1'b0;
  logic        evtAbort = 1'b0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  int unsigned mReq = 0;
  int unsigned mEn  = 0;
  bit          mIrq = 0;
  localparam int unsigned LIVE = 32'h0000_2002;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqlatch_top u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .evtDone   (evtDone),
    .evtAbort  (evtAbort),
    .irqOut    (irqOut)
  );

  function automatic int unsigned rawNow();
    return (evtDone ? 32'h2 : 32'h0) | (evtAbort ? 32'h2000 : 32'h0);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReq <= 0; mEn <= 0; mIrq <= 0;
    end else begin
      int unsigned clr;
      clr = (regWrEn && regAddr == 8'h14) ? regWrData : 0;
      mReq <= ((mReq & ~clr) | rawNow()) & LIVE;
      if (regWrEn && regAddr == 8'h18) mEn <= regWrData & LIVE;
      mIrq <= (mReq & mEn) != 0;
    end
  end

  function automatic int unsigned expRead(input logic [7:0] a);
    case (a)
      8'h10:   return rawNow();
      8'h14:   return mReq;
      8'h18:   return mEn;
      8'h1C:   return mReq & mEn;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic [7:0] a, input logic we,
                      input logic [31:0] wd, input logic d, input logic ab);
    @(negedge clk);
    regAddr = a; regWrEn = we; regWrData = wd; evtDone = d; evtAbort = ab;
    #1;
    check(tag, "rdData", regRdData, expRead(a));
    check("R8", "irqOut", {31'b0, irqOut}, {31'b0, mIrq});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset values
    step("R1", 8'h14, 0, 0, 0, 0);
    step("R1", 8'h18, 0, 0, 0, 0);
    step("R1", 8'h1C, 0, 0, 0, 0);
    @(negedge clk); rstN = 1'b1;
    step("R1", 8'h14, 0, 0, 0, 0);
    // R2: live status view, writes ignored
    step("R2", 8'h10, 0, 0, 1, 0);
    step("R2", 8'h10, 0, 0, 0, 1);
    step("R2", 8'h10, 1, 32'hFFFF_FFFF, 0, 0);
    step("R2", 8'h14, 0, 0, 0, 0);
    step("R2", 8'h18, 0, 0, 0, 0);
    // R4: clear both captured bits
    step("R4", 8'h14, 1, 32'h0000_2002, 0, 0);
    step("R4", 8'h14, 0, 0, 0, 0);
    // R3: capture with mask at zero
    step("R3", 8'h14, 0, 0, 1, 0);
    step("R3", 8'h14, 0, 0, 0, 0);
    step("R3", 8'h1C, 0, 0, 0, 0);
    // R4: write zero keeps, write one clears
    step("R4", 8'h14, 1, 32'h0000_0000, 0, 0);
    step("R4", 8'h14, 1, 32'hFFFF_DFFD, 0, 0);
    step("R4", 8'h14, 1, 32'h0000_0002, 0, 0);
    step("R4", 8'h14, 0, 0, 0, 0);
    // R6: mask keeps only live bits
    step("R6", 8'h18, 1, 32'hFFFF_FFFF, 0, 0);
    step("R6", 8'h18, 0, 0, 0, 0);
    // R5: event and clear on same edge
    step("R5", 8'h14, 1, 32'h0000_2000, 0, 1);
    step("R5", 8'h14, 0, 0, 0, 0);
    // R7 / R8: detect and interrupt
    step("R7", 8'h1C, 0, 0, 0, 0);
    step("R8", 8'h1C, 0, 0, 0, 0);
    step("R7", 8'h1C, 1, 32'h0000_0000, 0, 0);
    step("R7", 8'h1C, 0, 0, 0, 0);
    step("R8", 8'h18, 1, 32'h0000_0002, 0, 0);
    step("R8", 8'h1C, 0, 0, 0, 0);
    step("R8", 8'h1C, 0, 0, 0, 0);
    step("R8", 8'h14, 1, 32'h0000_2000, 0, 0);
    step("R8", 8'h1C, 0, 0, 0, 0);
    step("R8", 8'h1C, 0, 0, 0, 0);
    // R10: both events in one cycle, cleared separately
    step("R10", 8'h18, 1, 32'h0000_2002, 1, 1);
    step("R10", 8'h14, 0, 0, 0, 0);
    step("R10", 8'h14, 1, 32'h0000_0002, 0, 0);
    step("R10", 8'h14, 0, 0, 0, 0);
    step("R10", 8'h1C, 0, 0, 0, 0);
    step("R10", 8'h14, 1, 32'h0000_2000, 0, 0);
    step("R10", 8'h1C, 0, 0, 0, 0);
    // R9: unmapped addresses and unused bits
    step("R9", 8'h00, 0, 0, 1, 1);
    step("R9", 8'h20, 0, 0, 0, 0);
    step("R9", 8'h04, 1, 32'hFFFF_FFFF, 0, 0);
    step("R9", 8'h14, 0, 0, 0, 0);
    step("R9", 8'h18, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a;
      a = 8'h10 + 8'((i % 4) * 4);
      step("R3", a, (i % 3) == 0, (i % 2) ? 32'h2 : 32'h2002, (i % 5) == 1, (i % 7) == 2);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule